// File: doc/BRIEF.md
# Region address remapping unit

This unit sits on an instruction-fetch path and translates fetch addresses through a small set of programmable windows. Each of four windows has a power-of-two size between 2 MB and 128 MB, a base that selects which fetch addresses fall inside it, and a target that replaces the upper address bits of a fetch that hits. A hit window also chooses which of two downstream master ports the fetch leaves on, and whether the downstream access is a wrapping or an incrementing burst. A fetch that hits no window goes out unchanged.

Window settings are written as one control word per window. Writes are refused while the cache in front of this unit is switched on. A window that is already switched on refuses any write that would leave it switched on, so it must be switched off before it is set up again. Each fetch is decoded combinationally and the result is registered, so a fetch presented in one cycle appears at the outputs in the next.

Top module: `addr_remap_unit`

## Requirements
- R1: After reset every window is off with size code 1 (2 MB), so every fetch leaves unchanged, with out_hit_o 0, out_port_o 0 and out_incr_o 0.
- R2: A fetch accepted with fetch_valid_i high in one cycle produces out_valid_o high with its result in the next cycle; out_valid_o is low in a cycle after one with no fetch, and results come out in fetch order.
- R3: A fetch hits a window when the window is on and fetch address bits 28 down to the window's size boundary equal the matching bits of its base field; fetch address bits 31 to 29 never take part in the comparison.
- R4: Control word bits 3:1 hold the size code; code k from 1 to 7 means 2^k MB, code 0 means 2 MB. The base field (bits 11:4) lines up with fetch bits 28:21 and its lowest k-1 bits are ignored for code k.
- R5: On a hit, output address bits 31 down to the size boundary come from the remap field (control word bits 22:12, lined up with address bits 31:21), whose lowest k-1 bits are ignored for code k; the address bits below the boundary are passed on unchanged.
- R6: On a hit, out_port_o equals control word bit 23 of the hit window and out_incr_o equals control word bit 24 (1 incrementing burst, 0 wrapping burst).
- R7: When several windows hit, the lowest-numbered one is used and out_region_o reports its number.
- R8: A fetch that hits no window leaves with its address unchanged, out_hit_o 0, out_port_o 0 and out_incr_o 0 (wrapping).
- R9: A control word write while cache_en_i is high has no effect.
- R10: A write to a window that is on takes effect only when the written word has enable bit 0 low; a write with bit 0 high to a window that is on has no effect.
- R11: The four windows are independent: each has its own enable bit, and switching one off leaves the others' mapping in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en_i | input | 1 | Cache switched on; blocks control writes |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_idx_i | input | 2 | Window number written |
| cfg_wdata_i | input | 25 | Control word: bit0 enable, 3:1 size code, 11:4 base, 22:12 remap, 23 port, 24 incrementing burst |
| fetch_valid_i | input | 1 | Fetch address present |
| fetch_addr_i | input | 32 | Fetch address |
| out_valid_o | output | 1 | Translated fetch present |
| out_hit_o | output | 1 | Fetch hit a window |
| out_region_o | output | 2 | Number of the window used |
| out_addr_o | output | 32 | Translated address |
| out_port_o | output | 1 | Master port select |
| out_incr_o | output | 1 | 1 incrementing burst, 0 wrapping burst |

## Verification
The hardest situation to reach is two windows of different sizes overlapping the same fetch while one of them is being switched off, because the priority, the size-dependent masks and the write lock all act at once. The stimulus programs a small window and a larger window over a shared address, probes addresses inside both and inside only the larger one, then switches the smaller window off and probes again. Control words carry junk in the low base and remap bits so that masking errors change the outputs, and fetches use non-zero bits 31:29 to show they are ignored.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int ADDR_W       = 32;
    localparam int BOUND_LSB    = 21;
    localparam int BASE_W       = 8;
    localparam int REMAP_W      = ADDR_W - BOUND_LSB;
    localparam int SIZE_W       = 3;
    localparam int REGION_COUNT = 4;

    // Control word, LSB first: en, size, base, remap, port, incr
    typedef struct packed {
        logic               incr;
        logic               port;
        logic [REMAP_W-1:0] remap;
        logic [BASE_W-1:0]  base;
        logic [SIZE_W-1:0]  size;
        logic               en;
    } region_cfg_t;

    localparam int CFG_W = $bits(region_cfg_t);

    // Number of low base/remap bits dropped for a size code
    function automatic logic [SIZE_W-1:0] size_shift(input logic [SIZE_W-1:0] code);
        return (code == '0) ? '0 : code - SIZE_W'(1);
    endfunction
endpackage

// File: rtl/remap_region_cfg.sv
module remap_region_cfg
    import remap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cache_en_i,
    input  logic        wr_i,
    input  region_cfg_t wdata_i,
    output region_cfg_t cfg_o
);
    region_cfg_t cfg_d, cfg_q;
    logic        accept;

    always_comb begin
        cfg_d  = cfg_q;
        accept = wr_i && !cache_en_i && (!cfg_q.en || !wdata_i.en);
        if (accept) begin
            cfg_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.size <= SIZE_W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    assert_locked_cache_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && cache_en_i) |=> $stable(cfg_q));

    assert_no_reenable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && cfg_q.en && wdata_i.en) |=> $stable(cfg_q));

    assert_write_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !cache_en_i && !cfg_q.en) |=> (cfg_q == $past(wdata_i)));
endmodule

// File: rtl/remap_region_match.sv
module remap_region_match
    import remap_pkg::*;
(
    input  region_cfg_t       cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] xlat_o
);
    logic [SIZE_W-1:0]  sh;
    logic [BASE_W-1:0]  base_mask;
    logic [REMAP_W-1:0] remap_mask;
    logic [BASE_W-1:0]  addr_base;
    logic [REMAP_W-1:0] addr_top;

    always_comb begin
        sh         = size_shift(cfg_i.size);
        base_mask  = {BASE_W{1'b1}} << sh;
        remap_mask = {REMAP_W{1'b1}} << sh;
        addr_base  = addr_i[BOUND_LSB+BASE_W-1:BOUND_LSB];
        addr_top   = addr_i[ADDR_W-1:BOUND_LSB];
        hit_o      = cfg_i.en && (((addr_base ^ cfg_i.base) & base_mask) == '0);
        xlat_o     = {(cfg_i.remap & remap_mask) | (addr_top & ~remap_mask),
                      addr_i[BOUND_LSB-1:0]};
    end
endmodule

// File: rtl/remap_select.sv
module remap_select
    import remap_pkg::*;
#(
    parameter int NUM_REGIONS = REGION_COUNT,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [NUM_REGIONS-1:0]             hit_i,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] xlat_i,
    input  logic [NUM_REGIONS-1:0]             port_i,
    input  logic [NUM_REGIONS-1:0]             incr_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    output logic                               hit_o,
    output logic [IDX_W-1:0]                   idx_o,
    output logic [ADDR_W-1:0]                  addr_o,
    output logic                               port_o,
    output logic                               incr_o
);
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        addr_o = addr_i;
        port_o = 1'b0;
        incr_o = 1'b0;
        // Highest first so the lowest-numbered hit is written last
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (hit_i[r]) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(r);
                addr_o = xlat_i[r];
                port_o = port_i[r];
                incr_o = incr_i[r];
            end
        end
    end
endmodule

// File: rtl/addr_remap_unit.sv
module addr_remap_unit
    import remap_pkg::*;
#(
    parameter int NUM_REGIONS = REGION_COUNT,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en_i,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              out_valid_o,
    output logic              out_hit_o,
    output logic [IDX_W-1:0]  out_region_o,
    output logic [ADDR_W-1:0] out_addr_o,
    output logic              out_port_o,
    output logic              out_incr_o
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  region;
        logic [ADDR_W-1:0] addr;
        logic              port;
        logic              incr;
    } result_t;

    region_cfg_t                       cfg   [NUM_REGIONS];
    logic [NUM_REGIONS-1:0]            hit_v;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] xlat_v;
    logic [NUM_REGIONS-1:0]            port_v;
    logic [NUM_REGIONS-1:0]            incr_v;

    logic              sel_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_port;
    logic              sel_incr;

    result_t res_d, res_q;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        remap_region_cfg i_cfg (
            .clk        (clk),
            .rst_n      (rst_n),
            .cache_en_i (cache_en_i),
            .wr_i       (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
            .wdata_i    (region_cfg_t'(cfg_wdata_i)),
            .cfg_o      (cfg[g])
        );

        remap_region_match i_match (
            .cfg_i  (cfg[g]),
            .addr_i (fetch_addr_i),
            .hit_o  (hit_v[g]),
            .xlat_o (xlat_v[g])
        );

        assign port_v[g] = cfg[g].port;
        assign incr_v[g] = cfg[g].incr;
    end

    remap_select #(.NUM_REGIONS(NUM_REGIONS)) i_select (
        .hit_i  (hit_v),
        .xlat_i (xlat_v),
        .port_i (port_v),
        .incr_i (incr_v),
        .addr_i (fetch_addr_i),
        .hit_o  (sel_hit),
        .idx_o  (sel_idx),
        .addr_o (sel_addr),
        .port_o (sel_port),
        .incr_o (sel_incr)
    );

    always_comb begin
        res_d        = '0;
        res_d.valid  = fetch_valid_i;
        if (fetch_valid_i) begin
            res_d.hit    = sel_hit;
            res_d.region = sel_idx;
            res_d.addr   = sel_addr;
            res_d.port   = sel_port;
            res_d.incr   = sel_incr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid_o  = res_q.valid;
    assign out_hit_o    = res_q.hit;
    assign out_region_o = res_q.region;
    assign out_addr_o   = res_q.addr;
    assign out_port_o   = res_q.port;
    assign out_incr_o   = res_q.incr;

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> out_valid_o);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |=> !out_valid_o);

    assert_low_bits_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> (out_addr_o[BOUND_LSB-1:0] == $past(fetch_addr_i[BOUND_LSB-1:0])));

    assert_miss_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && (hit_v == '0)) |=>
            (out_addr_o == $past(fetch_addr_i)) && !out_port_o && !out_incr_o && !out_hit_o);

    assert_hit_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> (out_hit_o == ($past(hit_v) != '0)));
endmodule

// File: tb/test_addr_remap_unit.sv
module test_addr_remap_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_idx_i = '0;
    logic [24:0] cfg_wdata_i = '0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] fetch_addr_i = '0;
    logic        out_valid_o, out_hit_o, out_port_o, out_incr_o;
    logic [1:0]  out_region_o;
    logic [31:0] out_addr_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_remap_unit i_addr_remap_unit (
        .clk(clk), .rst_n(rst_n), .cache_en_i(cache_en_i),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_wdata_i(cfg_wdata_i),
        .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
        .out_valid_o(out_valid_o), .out_hit_o(out_hit_o), .out_region_o(out_region_o),
        .out_addr_o(out_addr_o), .out_port_o(out_port_o), .out_incr_o(out_incr_o)
    );

    typedef struct {
        logic        hit;
        logic [1:0]  region;
        logic [31:0] addr;
        logic        port;
        logic        incr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    // Bench-side model of the four windows
    logic        m_en    [4];
    logic [2:0]  m_size  [4];
    logic [7:0]  m_base  [4];
    logic [10:0] m_remap [4];
    logic        m_port  [4];
    logic        m_incr  [4];

    function automatic logic [24:0] mk(input logic en, input logic [2:0] code,
        input logic [7:0] base, input logic [10:0] remap, input logic port, input logic incr);
        return {incr, port, remap, base, code, en};
    endfunction

    function automatic exp_t model(input logic [31:0] a, input string tag);
        exp_t e;
        e.hit = 1'b0; e.region = '0; e.addr = a; e.port = 1'b0; e.incr = 1'b0; e.tag = tag;
        for (int r = 3; r >= 0; r--) begin
            if (m_en[r]) begin
                int k;
                logic [31:0] lm;
                k  = (m_size[r] == 3'd0) ? 1 : int'(m_size[r]);
                lm = (32'd1 << (20 + k)) - 32'd1;
                if (((a & 32'h1FFF_FFFF) & ~lm) == ({3'b000, m_base[r], 21'd0} & ~lm)) begin
                    e.hit = 1'b1;
                    e.region = 2'(r);
                    e.addr = ({m_remap[r], 21'd0} & ~lm) | (a & lm);
                    e.port = m_port[r];
                    e.incr = m_incr[r];
                end
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] idx, input logic [24:0] w);
        @(negedge clk);
        fetch_valid_i = 1'b0;
        cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = w;
        if (!cache_en_i && (!m_en[idx] || !w[0])) begin
            m_en[idx] = w[0]; m_size[idx] = w[3:1]; m_base[idx] = w[11:4];
            m_remap[idx] = w[22:12]; m_port[idx] = w[23]; m_incr[idx] = w[24];
        end
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input string tag);
        @(negedge clk);
        fetch_valid_i = 1'b1;
        fetch_addr_i = a;
        q.push_back(model(a, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fetch_valid_i = 1'b0;
        end
    endtask

    // Monitor: compares each produced result with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid_o", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_hit_o == e.hit, e.tag, "hit", 32'(out_hit_o), 32'(e.hit));
                check(out_addr_o == e.addr, e.tag, "addr", out_addr_o, e.addr);
                check(out_port_o == e.port, e.tag, "port", 32'(out_port_o), 32'(e.port));
                check(out_incr_o == e.incr, e.tag, "incr", 32'(out_incr_o), 32'(e.incr));
                if (e.hit) begin
                    check(out_region_o == e.region, e.tag, "region",
                          32'(out_region_o), 32'(e.region));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            m_en[r] = 1'b0; m_size[r] = 3'd1; m_base[r] = '0;
            m_remap[r] = '0; m_port[r] = 1'b0; m_incr[r] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid_o && !out_hit_o, "R1", "reset outputs",
              {30'd0, out_valid_o, out_hit_o}, 32'd0);

        // R1: nothing is mapped after reset
        send(32'h1234_5678, "R1");
        send(32'h0000_0000, "R1");
        idle(1);

        // R3 R5 R6: window 0, 2 MB
        write_cfg(2'd0, mk(1'b1, 3'd1, 8'h40, 11'h123, 1'b1, 1'b1));
        send({3'b000, 8'h40, 21'h0_ABCD}, "R5");
        send({3'b101, 8'h40, 21'h1F_FFFF}, "R3");
        send({3'b011, 8'h40, 21'h00_0001}, "R6");
        // R8: neighbour address misses
        send({3'b000, 8'h41, 21'h00_0005}, "R8");
        idle(1);

        // R9: write blocked while cache is on
        cache_en_i = 1'b1;
        write_cfg(2'd1, mk(1'b1, 3'd1, 8'h10, 11'h7FF, 1'b0, 1'b1));
        cache_en_i = 1'b0;
        send({3'b000, 8'h10, 21'h77}, "R9");
        idle(1);

        // R10: enabled window refuses re-setup, accepts switch-off
        write_cfg(2'd0, mk(1'b1, 3'd1, 8'h50, 11'h2AA, 1'b0, 1'b0));
        send({3'b000, 8'h40, 21'h123}, "R10");
        send({3'b000, 8'h50, 21'h123}, "R10");
        write_cfg(2'd0, mk(1'b0, 3'd1, 8'h50, 11'h2AA, 1'b0, 1'b0));
        send({3'b000, 8'h40, 21'h123}, "R10");
        write_cfg(2'd0, mk(1'b1, 3'd1, 8'h50, 11'h2AA, 1'b0, 1'b0));
        send({3'b000, 8'h50, 21'h456}, "R10");
        idle(1);

        // R4 R5: 128 MB window with junk low base and remap bits
        write_cfg(2'd1, mk(1'b1, 3'd7, 8'hC5, 11'h7C3, 1'b1, 1'b0));
        send(32'h1F12_3456, "R4");
        send(32'h1812_3456, "R5");
        send(32'h0F00_0000, "R4");
        idle(1);

        // R4: code 0 behaves as 2 MB
        write_cfg(2'd2, mk(1'b1, 3'd0, 8'h22, 11'h011, 1'b0, 1'b1));
        send({3'b000, 8'h22, 21'h1_2345}, "R4");
        send({3'b000, 8'h23, 21'h1_2345}, "R4");
        idle(1);

        // R7 R11: overlapping 4 MB window 3
        write_cfg(2'd3, mk(1'b1, 3'd2, 8'h22, 11'h100, 1'b1, 1'b1));
        send({3'b000, 8'h22, 21'h0_0010}, "R7");
        send({3'b000, 8'h23, 21'h0_0010}, "R11");
        write_cfg(2'd2, mk(1'b0, 3'd0, 8'h22, 11'h011, 1'b0, 1'b1));
        send({3'b000, 8'h22, 21'h0_0020}, "R11");
        send({3'b000, 8'h50, 21'h0_0020}, "R11");
        idle(1);

        // R2: back-to-back fetches
        send(32'h1F00_0004, "R2");
        send({3'b000, 8'h50, 21'h8}, "R2");
        send(32'h0000_1000, "R2");
        send({3'b000, 8'h23, 21'hC}, "R2");
        idle(4);

        check(q.size() == 0, "R2", "pending results", 32'(q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule